// File: doc/BRIEF.md
# Mode-Coded Serial Command Interface

This block is the host-facing serial slave of a display controller. A host frames each transfer with an active-high chip select, sends bits on the rising edges of a serial clock, least significant bit first, and ends each frame with a three-bit mode code. The mode code, taken from the last three bits of the frame, sets what the payload before it means. The payload can be a 32-bit segment pattern for one or all of three grid latches, a 10-bit brightness code, or nothing at all for the pure command frames. The stop-scanning command raises a one-cycle strobe. The two read commands prepare a readout of the switch status word or of the eight converter results.

All pins are sampled in the system clock domain, and edges of chip select and serial clock are found by comparing each sample with the one before. A frame takes effect only when chip select falls, and only if its bit count matches the length its mode requires. A read command takes effect at the next rise of chip select. At that rise the block captures the source word, takes over the data pin, and moves one bit on per serial clock rising edge. When chip select drops, it releases the pin.

Top module: `vfd_cmd_serial`

## Requirements
- R1: After reset all three grid latches and the brightness latch are 0, `sd_oe`, `sd_out` and `scan_stop` are 0.
- R2: A bit is accepted only on a rising `sclk` seen while `cs` is high; toggles of `sclk` or `sd_in` while `cs` is low leave no trace in the next frame.
- R3: A 35-bit frame whose last three bits (M0, M1, M2 in that order, value M0 + 2·M1 + 4·M2) are 0 writes its first 32 bits into all three grid latches, the first bit sent going to bit 0.
- R4: A 35-bit frame with mode 1, 2 or 3 writes only `grid1_seg`, `grid2_seg` or `grid3_seg` respectively.
- R5: A 13-bit frame with mode 4 writes its first 10 bits into `dim_code`, the first bit sent going to bit 0.
- R6: A 3-bit frame with mode 5 makes `scan_stop` high for exactly one clock cycle.
- R7: A frame whose bit count differs from the length its mode needs (35 for modes 0–3, 13 for mode 4, 3 for modes 5–7) changes no latch, raises no strobe and arms no readout.
- R8: Latches and the strobe change only in the clock cycle after `cs` is first sampled low; while `cs` stays high they hold.
- R9: After an accepted 3-bit mode 6 frame, the next rise of `cs` sets `sd_oe` and puts `sw_status[0]` on `sd_out`; each later rising `sclk` moves to the next bit, and zeros follow the 37th bit.
- R10: After an accepted 3-bit mode 7 frame, the readout sends `conv_res[63:0]` from bit 0 upward: channel 1 in bits 7:0 with its LSB first, through channel 8 in bits 63:56.
- R11: The readout word is captured at the `cs` rise that starts the read; later changes of `sw_status` or `conv_res` do not alter it.
- R12: When `cs` falls during a readout, `sd_oe` and `sd_out` return to 0 on the next cycle; bits clocked in during a readout are never decoded as a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high, frames a transfer |
| sclk | input | 1 | Serial clock from the host |
| sd_in | input | 1 | Serial data from the host |
| sd_out | output | 1 | Serial data towards the host during a readout |
| sd_oe | output | 1 | Drive enable for the shared data pin |
| grid1_seg | output | 32 | Segment pattern latch for grid 1 |
| grid2_seg | output | 32 | Segment pattern latch for grid 2 |
| grid3_seg | output | 32 | Segment pattern latch for grid 3 |
| dim_code | output | 10 | Brightness code latch |
| scan_stop | output | 1 | One-cycle stop-scanning strobe |
| sw_status | input | 37 | Switch status word returned by mode 6 |
| conv_res | input | 64 | Eight 8-bit converter results returned by mode 7 |

## Verification
The assertions assume that `cs`, `sclk` and `sd_in` are already synchronous to `clk`, that each level of `cs` and `sclk` lasts at least one clock, and that `sclk` does not rise in the same cycle `cs` rises. The bench drives every pin on the falling edge of `clk` and holds each `sclk` phase and each chip-select gap for at least one full cycle, so every edge the block sees is clean and isolated. A behavioural model built on bit queues runs beside the design and is compared on every cycle. Directed checks with fixed expected words cover each mode, the mismatched lengths and the readout snapshot.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      MD_SEG_ALL  = 3'd0,
      MD_SEG_G1   = 3'd1,
      MD_SEG_G2   = 3'd2,
      MD_SEG_G3   = 3'd3,
      MD_DIM      = 3'd4,
      MD_SCAN_OFF = 3'd5,
      MD_RD_SW    = 3'd6,
      MD_RD_CONV  = 3'd7
   } mode_e;

   typedef enum logic [1:0] {
      RD_NONE = 2'd0,
      RD_SW   = 2'd1,
      RD_CONV = 2'd2
   } rdsel_e;
endpackage

// File: rtl/vcs_edge.sv
module vcs_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sclk,
   output logic cs_rise,
   output logic cs_fall,
   output logic sclk_rise
);
   logic cs_q;
   logic sclk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs_q   <= 1'b0;
         sclk_q <= 1'b0;
      end else begin
         cs_q   <= cs;
         sclk_q <= sclk;
      end
   end

   assign cs_rise   = cs & ~cs_q;
   assign cs_fall   = ~cs & cs_q;
   assign sclk_rise = sclk & ~sclk_q;
endmodule

// File: rtl/vcs_rx.sv
module vcs_rx #(
   parameter int SH_W  = 35,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs,
   input  logic             cs_rise,
   input  logic             sclk_rise,
   input  logic             sd_in,
   input  logic             rd_act,
   output logic [SH_W-1:0]  sh,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] CAP = CNT_W'(SH_W + 1);

   initial begin
      if (SH_W + 1 >= (1 << CNT_W))
         $error("vcs_rx: CNT_W too small for SH_W");
   end

   logic take;
   assign take = sclk_rise & cs & ~rd_act & ~cs_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh  <= '0;
         cnt <= '0;
      end else begin
         if (cs_rise)
            cnt <= '0;
         if (take) begin
            sh <= {sd_in, sh[SH_W-1:1]};
            if (cnt != CAP)
               cnt <= cnt + 1'b1;
         end
      end
   end

   // R7: the counter saturates so overlong frames never alias a valid length
   p_cnt_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CAP);

   // R12: nothing enters the window while a readout owns the pin
   p_rx_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_act |=> $stable(sh));
endmodule

// File: rtl/vcs_dec.sv
module vcs_dec
   import vcs_pkg::*;
#(
   parameter int SEG_W = 32,
   parameter int DIM_W = 10,
   parameter int NGRID = 3,
   parameter int CNT_W = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cs_fall,
   input  logic [SEG_W+MODE_W-1:0]      sh,
   input  logic [CNT_W-1:0]             cnt,
   output logic [NGRID-1:0][SEG_W-1:0]  grid_lat,
   output logic [DIM_W-1:0]             dim_lat,
   output logic                         stop_pls,
   output rdsel_e                       rd_req
);
   localparam int SH_W = SEG_W + MODE_W;
   localparam logic [CNT_W-1:0] LEN_SEG = CNT_W'(SEG_W + MODE_W);
   localparam logic [CNT_W-1:0] LEN_DIM = CNT_W'(DIM_W + MODE_W);
   localparam logic [CNT_W-1:0] LEN_CMD = CNT_W'(MODE_W);

   if (NGRID < 1 || NGRID > 3) begin : g_bad_grid
      initial $error("vcs_dec: NGRID must be 1 to 3");
   end
   if (DIM_W > SEG_W) begin : g_bad_dim
      initial $error("vcs_dec: DIM_W must not exceed SEG_W");
   end

   mode_e            mode;
   logic [CNT_W-1:0] need_len;
   logic             accept;
   logic [SEG_W-1:0] seg_field;
   logic [DIM_W-1:0] dim_field;

   assign mode      = mode_e'(sh[SH_W-1 -: MODE_W]);
   assign seg_field = sh[SH_W-MODE_W-1 -: SEG_W];
   assign dim_field = sh[SH_W-MODE_W-1 -: DIM_W];

   always_comb begin
      case (mode)
         MD_SEG_ALL, MD_SEG_G1, MD_SEG_G2, MD_SEG_G3: need_len = LEN_SEG;
         MD_DIM:                                      need_len = LEN_DIM;
         default:                                     need_len = LEN_CMD;
      endcase
   end

   assign accept = cs_fall & (cnt == need_len);

   always_comb begin
      rd_req = RD_NONE;
      if (accept && mode == MD_RD_SW)   rd_req = RD_SW;
      if (accept && mode == MD_RD_CONV) rd_req = RD_CONV;
   end

   for (genvar g = 0; g < NGRID; g++) begin : g_grid
      logic wr;
      assign wr = accept & ((mode == MD_SEG_ALL) || (mode == mode_e'(g + 1)));

      always_ff @(posedge clk) begin
         if (!rst_n)
            grid_lat[g] <= '0;
         else if (wr)
            grid_lat[g] <= seg_field;
      end

      // R8: a grid latch moves only right after a chip-select fall
      p_grid_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !cs_fall |=> $stable(grid_lat[g]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dim_lat  <= '0;
         stop_pls <= 1'b0;
      end else begin
         if (accept && mode == MD_DIM)
            dim_lat <= dim_field;
         stop_pls <= accept && (mode == MD_SCAN_OFF);
      end
   end

   // R6: the stop strobe lasts one cycle
   p_stop_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pls |=> !stop_pls);

   // R8: the brightness latch holds while no frame ends
   p_dim_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_fall |=> $stable(dim_lat));
endmodule

// File: rtl/vcs_tx.sv
module vcs_tx
   import vcs_pkg::*;
#(
   parameter int SW_W   = 37,
   parameter int CONV_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_rise,
   input  logic              cs_fall,
   input  logic              sclk_rise,
   input  rdsel_e            rd_req,
   input  logic [SW_W-1:0]   sw_status,
   input  logic [CONV_W-1:0] conv_res,
   output logic              rd_act,
   output logic              sd_out
);
   localparam int SNAP_W = (SW_W > CONV_W) ? SW_W : CONV_W;

   logic [SNAP_W-1:0] sw_ext;
   logic [SNAP_W-1:0] conv_ext;
   logic [SNAP_W-1:0] src;
   logic [SNAP_W-1:0] snap;
   rdsel_e            armed;

   if (SW_W < SNAP_W) begin : g_sw_pad
      assign sw_ext = {{(SNAP_W-SW_W){1'b0}}, sw_status};
   end else begin : g_sw_full
      assign sw_ext = sw_status;
   end

   if (CONV_W < SNAP_W) begin : g_cv_pad
      assign conv_ext = {{(SNAP_W-CONV_W){1'b0}}, conv_res};
   end else begin : g_cv_full
      assign conv_ext = conv_res;
   end

   assign src = (armed == RD_SW) ? sw_ext : conv_ext;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed  <= RD_NONE;
         rd_act <= 1'b0;
         snap   <= '0;
         sd_out <= 1'b0;
      end else if (cs_fall) begin
         rd_act <= 1'b0;
         sd_out <= 1'b0;
         armed  <= rd_req;
      end else if (cs_rise) begin
         armed <= RD_NONE;
         if (armed != RD_NONE) begin
            rd_act <= 1'b1;
            snap   <= src;
            sd_out <= src[0];
         end
      end else if (rd_act && sclk_rise) begin
         snap   <= {1'b0, snap[SNAP_W-1:1]};
         sd_out <= snap[1];
      end
   end

   // R11: the output bit holds between serial clock edges
   p_out_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_act && !sclk_rise && !cs_fall) |=> $stable(sd_out));

   // R12: a chip-select fall releases the pin
   p_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> (!rd_act && !sd_out));

   // R9: a readout can only start from an armed request
   p_start_armed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_act) |-> $past(armed != RD_NONE));
endmodule

// File: rtl/vfd_cmd_serial.sv
module vfd_cmd_serial
   import vcs_pkg::*;
#(
   parameter int SEG_W = 32,
   parameter int DIM_W = 10,
   parameter int SW_W  = 37,
   parameter int NCH   = 8,
   parameter int CH_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs,
   input  logic               sclk,
   input  logic               sd_in,
   output logic               sd_out,
   output logic               sd_oe,
   output logic [SEG_W-1:0]   grid1_seg,
   output logic [SEG_W-1:0]   grid2_seg,
   output logic [SEG_W-1:0]   grid3_seg,
   output logic [DIM_W-1:0]   dim_code,
   output logic               scan_stop,
   input  logic [SW_W-1:0]    sw_status,
   input  logic [NCH*CH_W-1:0] conv_res
);
   localparam int NGRID  = 3;
   localparam int SH_W   = SEG_W + MODE_W;
   localparam int CNT_W  = $clog2(SH_W + 2) + 1;
   localparam int CONV_W = NCH * CH_W;

   logic                        cs_rise, cs_fall, sclk_rise;
   logic [SH_W-1:0]             sh;
   logic [CNT_W-1:0]            cnt;
   logic [NGRID-1:0][SEG_W-1:0] grid_lat;
   rdsel_e                      rd_req;
   logic                        rd_act;

   vcs_edge u_edge (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs        (cs),
      .sclk      (sclk),
      .cs_rise   (cs_rise),
      .cs_fall   (cs_fall),
      .sclk_rise (sclk_rise)
   );

   vcs_rx #(.SH_W(SH_W), .CNT_W(CNT_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs        (cs),
      .cs_rise   (cs_rise),
      .sclk_rise (sclk_rise),
      .sd_in     (sd_in),
      .rd_act    (rd_act),
      .sh        (sh),
      .cnt       (cnt)
   );

   vcs_dec #(.SEG_W(SEG_W), .DIM_W(DIM_W), .NGRID(NGRID), .CNT_W(CNT_W)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_fall  (cs_fall),
      .sh       (sh),
      .cnt      (cnt),
      .grid_lat (grid_lat),
      .dim_lat  (dim_code),
      .stop_pls (scan_stop),
      .rd_req   (rd_req)
   );

   vcs_tx #(.SW_W(SW_W), .CONV_W(CONV_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_rise   (cs_rise),
      .cs_fall   (cs_fall),
      .sclk_rise (sclk_rise),
      .rd_req    (rd_req),
      .sw_status (sw_status),
      .conv_res  (conv_res),
      .rd_act    (rd_act),
      .sd_out    (sd_out)
   );

   assign grid1_seg = grid_lat[0];
   assign grid2_seg = grid_lat[1];
   assign grid3_seg = grid_lat[2];
   assign sd_oe     = rd_act;

   // R12: the pin is never driven while chip select is seen low for two samples
   p_oe_needs_cs_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs && $past(!cs)) |-> !sd_oe);

   // R1: a reset cycle leaves every output quiet
   p_reset_quiet_r1: assert property (@(posedge clk)
      $past(!rst_n) |-> (!sd_oe && !scan_stop && dim_code == '0));
endmodule

// File: tb/tb_vfd_cmd_serial.sv
module tb_vfd_cmd_serial;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 1'b0, sclk = 1'b0, sd_in = 1'b0;
   logic        sd_out, sd_oe, scan_stop;
   logic [31:0] g1, g2, g3;
   logic [9:0]  dim;
   logic [36:0] sw_status = '0;
   logic [63:0] conv_res = '0;

   int nvec = 0, nmis = 0, stop_seen = 0;
   bit done = 0;

   always #10 clk = ~clk;

   vfd_cmd_serial dut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sd_in(sd_in),
      .sd_out(sd_out), .sd_oe(sd_oe),
      .grid1_seg(g1), .grid2_seg(g2), .grid3_seg(g3),
      .dim_code(dim), .scan_stop(scan_stop),
      .sw_status(sw_status), .conv_res(conv_res)
   );

   // behavioural reference: bit queues, updated on each rising clk
   bit          rq[$];
   bit          oq[$];
   logic [31:0] m_g[3];
   logic [9:0]  m_dim;
   logic        m_stop, m_oe, m_out;
   int          m_pend;   // 0 none, 6 switch, 7 converter
   logic        p_cs, p_sclk;

   always @(posedge clk) begin
      if (!rst_n) begin
         rq.delete(); oq.delete();
         for (int i = 0; i < 3; i++) m_g[i] = '0;
         m_dim = '0; m_stop = 0; m_oe = 0; m_out = 0; m_pend = 0;
         p_cs = 0; p_sclk = 0;
      end else begin
         m_stop = 0;
         if (!cs && p_cs) begin
            if (m_oe) begin
               m_oe = 0; m_out = 0; m_pend = 0;
            end else begin
               int n;
               int md;
               n = rq.size();
               m_pend = 0;
               if (n >= 3) begin
                  int want;
                  md = rq[n-3] + 2*rq[n-2] + 4*rq[n-1];
                  want = (md <= 3) ? 35 : (md == 4) ? 13 : 3;
                  if (n == want) begin
                     logic [31:0] pay;
                     pay = '0;
                     for (int k = 0; k < n-3 && k < 32; k++) pay[k] = rq[k];
                     if (md == 0) for (int i = 0; i < 3; i++) m_g[i] = pay;
                     else if (md <= 3) m_g[md-1] = pay;
                     else if (md == 4) m_dim = pay[9:0];
                     else if (md == 5) m_stop = 1;
                     else m_pend = md;
                  end
               end
            end
         end else if (cs && !p_cs) begin
            rq.delete();
            if (m_pend != 0) begin
               oq.delete();
               if (m_pend == 6) for (int k = 0; k < 37; k++) oq.push_back(sw_status[k]);
               else             for (int k = 0; k < 64; k++) oq.push_back(conv_res[k]);
               m_oe = 1; m_out = oq[0];
            end
            m_pend = 0;
         end else if (sclk && !p_sclk && cs) begin
            if (m_oe) begin
               if (oq.size() > 0) void'(oq.pop_front());
               m_out = (oq.size() > 0) ? oq[0] : 1'b0;
            end else begin
               rq.push_back(sd_in);
            end
         end
         p_cs = cs; p_sclk = sclk;
      end
   end

   task automatic cmp(string tag, logic [63:0] a, logic [63:0] e);
      nvec++;
      if (a !== e) begin
         nmis++;
         $display("FAIL %s: actual=%h expected=%h", tag, a, e);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         cmp("R3 R4 grid1_seg vs model", 64'(g1), 64'(m_g[0]));
         cmp("R3 R4 grid2_seg vs model", 64'(g2), 64'(m_g[1]));
         cmp("R3 R4 grid3_seg vs model", 64'(g3), 64'(m_g[2]));
         cmp("R5 dim_code vs model", 64'(dim), 64'(m_dim));
         cmp("R6 scan_stop vs model", 64'(scan_stop), 64'(m_stop));
         cmp("R9 R12 sd_oe vs model", 64'(sd_oe), 64'(m_oe));
         cmp("R9 R10 sd_out vs model", 64'(sd_out), 64'(m_out));
         if (scan_stop) stop_seen++;
      end
   end

   task automatic summary();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nmis++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      summary();
   end

   task automatic send(logic [63:0] v, int n);
      @(negedge clk) cs = 1;
      @(negedge clk);
      for (int i = 0; i < n; i++) begin
         sd_in = v[i]; sclk = 1;
         @(negedge clk) sclk = 0;
         @(negedge clk);
      end
      cs = 0;
      repeat (3) @(negedge clk);
   endtask

   task automatic read(int n, output logic [63:0] v, input logic [36:0] sw_mid);
      v = '0;
      @(negedge clk) cs = 1;
      @(negedge clk) v[0] = sd_out;
      for (int i = 1; i < n; i++) begin
         if (i == 5) sw_status = sw_mid;
         sd_in = i[0]; sclk = 1;
         @(negedge clk) v[i] = sd_out;
         sclk = 0;
         @(negedge clk);
      end
      cs = 0;
      @(negedge clk);
      cmp("R12 sd_oe released after cs low", 64'(sd_oe), 64'd0);
      repeat (2) @(negedge clk);
   endtask

   logic [63:0] rd;
   logic [36:0] sw_a;

   initial begin
      repeat (3) @(negedge clk);
      cmp("R1 grid latches at reset", 64'({g1 | g2 | g3}), 64'd0);
      cmp("R1 dim and strobe at reset", 64'({dim, scan_stop, sd_oe, sd_out}), 64'd0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R3: broadcast to all grids; R8 check while cs still high
      @(negedge clk) cs = 1;
      @(negedge clk);
      for (int i = 0; i < 35; i++) begin
         sd_in = (i < 32) ? 1'(32'hA5A51234 >> i) : 1'b0; sclk = 1;
         @(negedge clk) sclk = 0;
         @(negedge clk);
      end
      cmp("R8 grid1 unchanged before cs fall", 64'(g1), 64'd0);
      cs = 0;
      @(negedge clk);
      cmp("R8 grid1 updated one cycle after cs low", 64'(g1), 64'hA5A51234);
      repeat (2) @(negedge clk);
      cmp("R3 broadcast reaches all grids", 64'({g1 == 32'hA5A51234, g2 == 32'hA5A51234, g3 == 32'hA5A51234}), 64'd7);

      // R4 single-grid writes
      send({29'd0, 3'd2, 32'h0F0F0F0F}, 35);
      cmp("R4 mode 2 writes grid2", 64'(g2), 64'h0F0F0F0F);
      cmp("R4 mode 2 spares grid1", 64'(g1), 64'hA5A51234);
      send({29'd0, 3'd1, 32'h11111111}, 35);
      send({29'd0, 3'd3, 32'h33333333}, 35);
      cmp("R4 mode 1 writes grid1", 64'(g1), 64'h11111111);
      cmp("R4 mode 3 writes grid3", 64'(g3), 64'h33333333);
      cmp("R4 mode 3 spares grid2", 64'(g2), 64'h0F0F0F0F);

      // R5 brightness
      send({51'd0, 3'd4, 10'h155}, 13);
      cmp("R5 dim 0x155", 64'(dim), 64'h155);
      send({51'd0, 3'd4, 10'h3FF}, 13);
      cmp("R5 dim 0x3FF", 64'(dim), 64'h3FF);

      // R2 toggles with cs low are ignored
      for (int i = 0; i < 6; i++) begin
         @(negedge clk) sd_in = 1; sclk = 1;
         @(negedge clk) sclk = 0;
      end
      send({51'd0, 3'd4, 10'h2C3}, 13);
      cmp("R2 frame after cs-low toggles", 64'(dim), 64'h2C3);

      // R6 stop strobe
      send(64'd5, 3);
      cmp("R6 one stop pulse", 64'(stop_seen), 64'd1);

      // R7 mismatched lengths
      send({30'd0, 3'd0, 31'h7FFFFFFF}, 34);
      cmp("R7 short segment frame discarded", 64'(g1), 64'h11111111);
      send({28'd0, 3'd1, 32'hDEADBEEF, 1'b1}, 36);
      cmp("R7 long segment frame discarded", 64'(g1), 64'h11111111);
      send({60'd0, 3'd5, 1'b1}, 4);
      cmp("R7 4-bit stop frame ignored", 64'(stop_seen), 64'd1);
      send({60'd0, 3'd6, 1'b0}, 4);
      @(negedge clk) cs = 1;
      repeat (2) @(negedge clk);
      cmp("R7 bad read frame arms nothing", 64'(sd_oe), 64'd0);
      cs = 0;
      repeat (3) @(negedge clk);

      // R9 switch readout with R11 mid-read change
      sw_a = 37'h1A5C3C96E1;
      sw_status = sw_a;
      send(64'd6, 3);
      read(40, rd, ~sw_a);
      cmp("R9 switch word LSB first, zero tail", rd & 64'hFF_FFFF_FFFF, 64'(sw_a));
      cmp("R11 snapshot unaffected by mid-read change", rd & 64'h1F_FFFF_FFFF, 64'(sw_a));
      cmp("R12 grids untouched by bits sent during read", 64'(g1), 64'h11111111);

      // R10 converter readout
      conv_res = 64'h8877665544332211;
      send(64'd7, 3);
      read(64, rd, sw_status);
      cmp("R10 converter channels 1..8 LSB first", rd, 64'h8877665544332211);

      repeat (4) @(negedge clk);
      summary();
   end
endmodule